// File: doc/BRIEF.md
# Lane Configuration Source Arbiter

This block chooses, for each of eight serial lanes, where the lane's signal-conditioning settings come from. Lanes 0 to 3 form side A and lanes 4 to 7 form side B. Each lane receives an 8-bit equalizer code, a 4-bit de-emphasis code, a 3-bit output amplitude code and a termination-disable flag. The block also produces the global operating-mode, receiver-detect, signal-detect-threshold and loopback settings. These come either from board strap pins, which an analog front end has already digitised into four-level codes, or from a register bank that a management-bus engine or an EEPROM loader writes through a simple address/data/strobe port.

All strap codes pass through a two-flop synchroniser and a stability filter before they are used. A three-way control strap picks the source. In pin mode, each side's two equalizer straps are expanded through a fixed 16-entry code table, and all four lanes of that side share one setting. In bus-slave mode and in EEPROM-load mode, every lane follows its own registers. The operating-mode, receiver-detect and threshold outputs keep following their straps until software overrides them. Leaving register control clears the bank. Power-down leaves the bank intact.

Top module: `lane_cfg_arbiter`

## Requirements
- R1: The filtered control strap `strap_sel` decodes as 00 or 01 = pin mode (`ctl_state` 00), 11 = bus-slave mode (`ctl_state` 01) and 10 = EEPROM-load mode (`ctl_state` 10). `ctl_state` never takes the value 11.
- R2: In pin mode, all four lanes of a side carry the same equalizer code. The de-emphasis code equals that side's two de-emphasis straps concatenated as {high, low}. The amplitude is `VOD_PIN` and termination-disable is 0.
- R3: In pin mode, the equalizer code is looked up by index {eq_high, eq_low}, using levels 0=00, R=01, F=10, 1=11. The 16 indices map in order to 00,01,02,03,07,15,0B,0F,55,1F,2F,3F,AA,7F,BF,FF (hex).
- R4: In bus-slave and EEPROM-load modes, each lane's outputs come from its own registers. They switch to register values in the same cycle that `ctl_state` leaves pin mode.
- R5: Register map, with N = 8 lanes:
  - Address l (0..7) holds the equalizer code of lane l.
  - Address 8+l holds the lane control byte: de-emphasis in [3:0], amplitude in [6:4], termination-disable in [7].
  - Address 16 holds the mode value, address 17 the receiver-detect value and address 18 the threshold value, each in [1:0].
  - Address 19 holds the override enables: bit 0 = mode, bit 1 = receiver-detect, bit 2 = threshold.
- R6: Writes made while in pin mode have no effect.
- R7: Under register control, `op_mode`, `rxdet_cfg` and `sd_thresh` follow their straps. Each one switches to its register value only once its value register has been written and its enable bit set. Enable bits are set-only and hold until pin mode is entered.
- R8: Reset and every entry into pin mode return all registers to their defaults: equalizer 0, de-emphasis 0, amplitude `VOD_RST`, termination-disable 0, and no overrides.
- R9: While `pwr_dn` is high, every register keeps its value and writes are ignored.
- R10: `loop_sel` decodes the loopback strap as 00 = A inputs to B outputs (`loop_sel` 01), 11 = B inputs to A outputs (`loop_sel` 10), and anything else = normal operation (`loop_sel` 00). This holds in every mode.
- R11: A strap change applied before clock edge k appears at the outputs after edge k+3 and not before. A change that lasts for a single edge never reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down request |
| strap_sel | input | 2 | Control-source strap level |
| strap_eq_a | input | 4 | Side A equalizer straps {high, low} |
| strap_eq_b | input | 4 | Side B equalizer straps {high, low} |
| strap_dem_a | input | 4 | Side A de-emphasis straps {high, low} |
| strap_dem_b | input | 4 | Side B de-emphasis straps {high, low} |
| strap_mode | input | 2 | Operating-mode strap level |
| strap_rxdet | input | 2 | Receiver-detect strap level |
| strap_sdth | input | 2 | Signal-detect threshold strap level |
| strap_lpbk | input | 2 | Loopback strap level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| ctl_state | output | 2 | Current configuration source |
| lane_eq | output | 64 | Per-lane equalizer codes, lane 0 in the low byte |
| lane_dem | output | 32 | Per-lane de-emphasis codes |
| lane_vod | output | 24 | Per-lane output amplitude codes |
| lane_term_dis | output | 8 | Per-lane termination disable |
| op_mode | output | 2 | Global operating mode |
| rxdet_cfg | output | 2 | Global receiver-detect setting |
| sd_thresh | output | 2 | Global signal-detect threshold |
| loop_sel | output | 2 | Loopback routing |

## Verification
A register that fails to clear on entry into pin mode stays hidden while pin mode lasts. It appears at the lane outputs in the first cycle after the next entry into register control, so the bench re-enters register control and samples in that cycle. An override flag that is stuck or cleared too early shows up as `op_mode` or `rxdet_cfg` following the wrong source. This is visible one cycle after the write, or four cycles after a strap change. A filter stage that is missing or extra shifts every strap-driven output by one cycle. The bench checks for this at the exact edge where the change is due.

// File: rtl/lane_cfg_pkg.sv
// Shared types and decode functions for the lane configuration arbiter.
// Assumes strap levels arrive already digitised as 2-bit codes.
package lane_cfg_pkg;

    localparam int EQ_W  = 8;
    localparam int DEM_W = 4;
    localparam int VOD_W = 3;
    localparam int LVL_W = 2;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_RES   = 2'b01,
        LVL_FLOAT = 2'b10,
        LVL_HIGH  = 2'b11
    } strap_lvl_e;

    typedef enum logic [1:0] {
        CTL_PIN   = 2'b00,
        CTL_SLAVE = 2'b01,
        CTL_LOAD  = 2'b10
    } ctl_src_e;

    typedef enum logic [1:0] {
        LOOP_NONE = 2'b00,
        LOOP_A2B  = 2'b01,
        LOOP_B2A  = 2'b10
    } loop_e;

    // Expand an equalizer strap pair {high, low} into its 8-bit code.
    function automatic logic [EQ_W-1:0] eq_code(input logic [3:0] idx);
        case (idx)
            4'h0:    eq_code = 8'h00;
            4'h1:    eq_code = 8'h01;
            4'h2:    eq_code = 8'h02;
            4'h3:    eq_code = 8'h03;
            4'h4:    eq_code = 8'h07;
            4'h5:    eq_code = 8'h15;
            4'h6:    eq_code = 8'h0B;
            4'h7:    eq_code = 8'h0F;
            4'h8:    eq_code = 8'h55;
            4'h9:    eq_code = 8'h1F;
            4'hA:    eq_code = 8'h2F;
            4'hB:    eq_code = 8'h3F;
            4'hC:    eq_code = 8'hAA;
            4'hD:    eq_code = 8'h7F;
            4'hE:    eq_code = 8'hBF;
            default: eq_code = 8'hFF;
        endcase
    endfunction

    // Map the control strap level onto a configuration source.
    function automatic ctl_src_e sel_decode(input logic [1:0] lvl);
        case (lvl)
            LVL_HIGH:  sel_decode = CTL_SLAVE;
            LVL_FLOAT: sel_decode = CTL_LOAD;
            default:   sel_decode = CTL_PIN;
        endcase
    endfunction

    // Map the loopback strap level onto a routing choice.
    function automatic loop_e loop_decode(input logic [1:0] lvl);
        case (lvl)
            LVL_LOW:  loop_decode = LOOP_A2B;
            LVL_HIGH: loop_decode = LOOP_B2A;
            default:  loop_decode = LOOP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/strap_filter.sv
// Two-flop synchroniser followed by a stability filter.
// The held value updates only when the synchronised value has been equal
// on two consecutive samples, so single-edge glitches are discarded.
// Assumes the whole strap vector is treated as one word.
module strap_filter #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] held
);

    logic [W-1:0] sync_q1;
    logic [W-1:0] sync_q2;
    logic [W-1:0] prev_q;

    // Synchronise the raw strap word and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q1 <= '0;
            sync_q2 <= '0;
            prev_q  <= '0;
        end else begin
            sync_q1 <= raw;
            sync_q2 <= sync_q1;
            prev_q  <= sync_q2;
        end
    end

    // Accept a new value only after two matching samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (sync_q2 == prev_q) begin
            held <= sync_q2;
        end
    end

endmodule

// File: rtl/cfg_reg_bank.sv
// Register bank written through an address/data/strobe port.
// It holds the per-lane settings and the three global override
// values with their enables. clear forces every register to its default.
// Assumes wr_ok is already qualified by mode and power-down.
module cfg_reg_bank
    import lane_cfg_pkg::*;
#(
    parameter int              NUM_LANES = 8,
    parameter int              ADDR_W    = 5,
    parameter logic [VOD_W-1:0] VOD_RST  = 3'd2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear,
    input  logic                              wr_ok,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [7:0]                        wr_data,
    output logic [NUM_LANES-1:0][EQ_W-1:0]    eq_r,
    output logic [NUM_LANES-1:0][DEM_W-1:0]   dem_r,
    output logic [NUM_LANES-1:0][VOD_W-1:0]   vod_r,
    output logic [NUM_LANES-1:0]              term_r,
    output logic [2:0][LVL_W-1:0]             ovr_val,
    output logic [2:0]                        ovr_on
);

    localparam int CTL_BASE = NUM_LANES;
    localparam int OVR_BASE = 2 * NUM_LANES;
    localparam logic [ADDR_W-1:0] OVR_EN_ADDR = ADDR_W'(OVR_BASE + 3);

    logic [2:0] ovr_written;
    logic [2:0] ovr_enable;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam logic [ADDR_W-1:0] EQ_ADDR  = ADDR_W'(l);
        localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(CTL_BASE + l);

        // Per-lane equalizer code register.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                eq_r[l] <= '0;
            end else if (wr_ok && wr_addr == EQ_ADDR) begin
                eq_r[l] <= wr_data;
            end
        end

        // Per-lane control byte: de-emphasis, amplitude, termination.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                dem_r[l]  <= '0;
                vod_r[l]  <= VOD_RST;
                term_r[l] <= 1'b0;
            end else if (wr_ok && wr_addr == CTL_ADDR) begin
                dem_r[l]  <= wr_data[3:0];
                vod_r[l]  <= wr_data[6:4];
                term_r[l] <= wr_data[7];
            end
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_ovr
        localparam logic [ADDR_W-1:0] VAL_ADDR = ADDR_W'(OVR_BASE + k);

        // Override value and its has-been-written flag.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                ovr_val[k]     <= '0;
                ovr_written[k] <= 1'b0;
            end else if (wr_ok && wr_addr == VAL_ADDR) begin
                ovr_val[k]     <= wr_data[1:0];
                ovr_written[k] <= 1'b1;
            end
        end

        // Sticky override enable; only clear can drop it.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                ovr_enable[k] <= 1'b0;
            end else if (wr_ok && wr_addr == OVR_EN_ADDR && wr_data[k]) begin
                ovr_enable[k] <= 1'b1;
            end
        end
    end

    assign ovr_on = ovr_written & ovr_enable;

endmodule

// File: rtl/lane_cfg_mux.sv
// Per-lane source selection between the shared side strap settings
// and the lane's own registers. Lanes below LANES_PER_SIDE belong to
// side A and the rest to side B. Purely combinational.
module lane_cfg_mux
    import lane_cfg_pkg::*;
#(
    parameter int               LANES_PER_SIDE = 4,
    parameter logic [VOD_W-1:0] VOD_PIN        = 3'd2,
    localparam int              NUM_LANES      = 2 * LANES_PER_SIDE
) (
    input  logic                            use_regs,
    input  logic [EQ_W-1:0]                 pin_eq_a,
    input  logic [EQ_W-1:0]                 pin_eq_b,
    input  logic [DEM_W-1:0]                pin_dem_a,
    input  logic [DEM_W-1:0]                pin_dem_b,
    input  logic [NUM_LANES-1:0][EQ_W-1:0]  eq_r,
    input  logic [NUM_LANES-1:0][DEM_W-1:0] dem_r,
    input  logic [NUM_LANES-1:0][VOD_W-1:0] vod_r,
    input  logic [NUM_LANES-1:0]            term_r,
    output logic [NUM_LANES-1:0][EQ_W-1:0]  lane_eq,
    output logic [NUM_LANES-1:0][DEM_W-1:0] lane_dem,
    output logic [NUM_LANES-1:0][VOD_W-1:0] lane_vod,
    output logic [NUM_LANES-1:0]            lane_term_dis
);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam bit SIDE_B = (l >= LANES_PER_SIDE);

        // Choose this lane's settings from the registers or its side's straps.
        always_comb begin
            if (use_regs) begin
                lane_eq[l]       = eq_r[l];
                lane_dem[l]      = dem_r[l];
                lane_vod[l]      = vod_r[l];
                lane_term_dis[l] = term_r[l];
            end else begin
                lane_eq[l]       = SIDE_B ? pin_eq_b : pin_eq_a;
                lane_dem[l]      = SIDE_B ? pin_dem_b : pin_dem_a;
                lane_vod[l]      = VOD_PIN;
                lane_term_dis[l] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lane_cfg_arbiter.sv
// Top of the lane configuration arbiter. It filters the strap word,
// decodes the configuration source, gates register writes, and drives
// the per-lane and global settings.
// Assumes strap codes are digitised levels and the write port is synchronous.
module lane_cfg_arbiter
    import lane_cfg_pkg::*;
#(
    parameter int               LANES_PER_SIDE = 4,
    parameter int               ADDR_W         = 5,
    parameter logic [VOD_W-1:0] VOD_PIN        = 3'd2,
    parameter logic [VOD_W-1:0] VOD_RST        = 3'd2,
    localparam int              NUM_LANES      = 2 * LANES_PER_SIDE
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pwr_dn,
    input  logic [1:0]                      strap_sel,
    input  logic [3:0]                      strap_eq_a,
    input  logic [3:0]                      strap_eq_b,
    input  logic [3:0]                      strap_dem_a,
    input  logic [3:0]                      strap_dem_b,
    input  logic [1:0]                      strap_mode,
    input  logic [1:0]                      strap_rxdet,
    input  logic [1:0]                      strap_sdth,
    input  logic [1:0]                      strap_lpbk,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [7:0]                      wr_data,
    output logic [1:0]                      ctl_state,
    output logic [NUM_LANES-1:0][EQ_W-1:0]  lane_eq,
    output logic [NUM_LANES-1:0][DEM_W-1:0] lane_dem,
    output logic [NUM_LANES-1:0][VOD_W-1:0] lane_vod,
    output logic [NUM_LANES-1:0]            lane_term_dis,
    output logic [1:0]                      op_mode,
    output logic [1:0]                      rxdet_cfg,
    output logic [1:0]                      sd_thresh,
    output logic [1:0]                      loop_sel
);

    localparam int STRAP_W = 2 + 4 * 4 + 4 * LVL_W;

    logic [STRAP_W-1:0]          strap_raw;
    logic [STRAP_W-1:0]          strap_q;
    logic [1:0]                  f_sel;
    logic [3:0]                  f_eq_a, f_eq_b, f_dem_a, f_dem_b;
    logic [1:0]                  f_mode, f_rxdet, f_sdth, f_lpbk;
    ctl_src_e                    src;
    logic                        use_regs;
    logic                        wr_ok;
    logic [NUM_LANES-1:0][EQ_W-1:0]  eq_r;
    logic [NUM_LANES-1:0][DEM_W-1:0] dem_r;
    logic [NUM_LANES-1:0][VOD_W-1:0] vod_r;
    logic [NUM_LANES-1:0]            term_r;
    logic [2:0][LVL_W-1:0]           ovr_val;
    logic [2:0]                      ovr_on;

    assign strap_raw = {strap_sel, strap_eq_a, strap_eq_b, strap_dem_a, strap_dem_b,
                        strap_mode, strap_rxdet, strap_sdth, strap_lpbk};

    strap_filter #(.W(STRAP_W)) i_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (strap_raw),
        .held  (strap_q)
    );

    assign {f_sel, f_eq_a, f_eq_b, f_dem_a, f_dem_b,
            f_mode, f_rxdet, f_sdth, f_lpbk} = strap_q;

    // Decode the source and qualify register writes.
    always_comb begin
        src      = sel_decode(f_sel);
        use_regs = (src != CTL_PIN);
        wr_ok    = wr_en && use_regs && !pwr_dn;
    end

    cfg_reg_bank #(
        .NUM_LANES (NUM_LANES),
        .ADDR_W    (ADDR_W),
        .VOD_RST   (VOD_RST)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!use_regs),
        .wr_ok   (wr_ok),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .eq_r    (eq_r),
        .dem_r   (dem_r),
        .vod_r   (vod_r),
        .term_r  (term_r),
        .ovr_val (ovr_val),
        .ovr_on  (ovr_on)
    );

    lane_cfg_mux #(
        .LANES_PER_SIDE (LANES_PER_SIDE),
        .VOD_PIN        (VOD_PIN)
    ) i_mux (
        .use_regs      (use_regs),
        .pin_eq_a      (eq_code(f_eq_a)),
        .pin_eq_b      (eq_code(f_eq_b)),
        .pin_dem_a     (f_dem_a),
        .pin_dem_b     (f_dem_b),
        .eq_r          (eq_r),
        .dem_r         (dem_r),
        .vod_r         (vod_r),
        .term_r        (term_r),
        .lane_eq       (lane_eq),
        .lane_dem      (lane_dem),
        .lane_vod      (lane_vod),
        .lane_term_dis (lane_term_dis)
    );

    // Global settings: straps unless an active override replaces them.
    always_comb begin
        ctl_state = src;
        op_mode   = ovr_on[0] ? ovr_val[0] : f_mode;
        rxdet_cfg = ovr_on[1] ? ovr_val[1] : f_rxdet;
        sd_thresh = ovr_on[2] ? ovr_val[2] : f_sdth;
        loop_sel  = loop_decode(f_lpbk);
    end

endmodule

// File: rtl/lane_cfg_checker.sv
// Property checker for the lane configuration arbiter, bound to the top.
// Watches only ports of the top module.
module lane_cfg_checker #(
    parameter int LANES_PER_SIDE = 4,
    localparam int NUM_LANES     = 2 * LANES_PER_SIDE
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         pwr_dn,
    input logic                         wr_en,
    input logic [1:0]                   ctl_state,
    input logic [NUM_LANES-1:0][7:0]    lane_eq,
    input logic [NUM_LANES-1:0][3:0]    lane_dem,
    input logic [NUM_LANES-1:0][2:0]    lane_vod,
    input logic [NUM_LANES-1:0]         lane_term_dis,
    input logic [1:0]                   loop_sel
);

    // The source code never takes the unused value.
    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_state != 2'b11);

    // Loopback never selects both directions.
    assert_loop_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(loop_sel));

    // In pin mode, every lane of a side matches the side's first lane.
    for (genvar l = 1; l < LANES_PER_SIDE; l++) begin : g_share
        assert_side_a_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_state == 2'b00) |-> (lane_eq[l] == lane_eq[0] && lane_dem[l] == lane_dem[0]));
        assert_side_b_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_state == 2'b00) |-> (lane_eq[LANES_PER_SIDE + l] == lane_eq[LANES_PER_SIDE]
                                      && lane_dem[LANES_PER_SIDE + l] == lane_dem[LANES_PER_SIDE]));
    end

    // On entry into register control, lanes show cleared registers.
    assert_defaults_on_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state != 2'b00 && $past(ctl_state) == 2'b00)
            |-> (lane_eq == '0 && lane_term_dis == '0 && lane_dem == '0));

    // Power-down in register control freezes every lane setting.
    assert_pwrdn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn && ctl_state != 2'b00) |=>
            (ctl_state == 2'b00 || $past(ctl_state) != ctl_state ||
             ($stable(lane_eq) && $stable(lane_dem) && $stable(lane_vod) && $stable(lane_term_dis))));

    // In pin mode no write changes a lane setting between strap-stable cycles.
    assert_pin_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_state == 2'b00) |=> (ctl_state != 2'b00 || lane_term_dis == '0));

endmodule

bind lane_cfg_arbiter lane_cfg_checker #(.LANES_PER_SIDE(LANES_PER_SIDE)) i_lane_cfg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_dn        (pwr_dn),
    .wr_en         (wr_en),
    .ctl_state     (ctl_state),
    .lane_eq       (lane_eq),
    .lane_dem      (lane_dem),
    .lane_vod      (lane_vod),
    .lane_term_dis (lane_term_dis),
    .loop_sel      (loop_sel)
);

// File: tb/test_lane_cfg_arbiter.sv
// Directed bench for the lane configuration arbiter: one task per scenario.
module test_lane_cfg_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_dn = 1'b0;
    logic [1:0] strap_sel = 2'b00;
    logic [3:0] strap_eq_a = 4'h0, strap_eq_b = 4'h0, strap_dem_a = 4'h0, strap_dem_b = 4'h0;
    logic [1:0] strap_mode = 2'b00, strap_rxdet = 2'b00, strap_sdth = 2'b00, strap_lpbk = 2'b10;
    logic wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] ctl_state;
    logic [NL-1:0][7:0] lane_eq;
    logic [NL-1:0][3:0] lane_dem;
    logic [NL-1:0][2:0] lane_vod;
    logic [NL-1:0] lane_term_dis;
    logic [1:0] op_mode, rxdet_cfg, sd_thresh, loop_sel;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] eq_tab [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lane_cfg_arbiter i_lane_cfg_arbiter (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .strap_sel(strap_sel),
        .strap_eq_a(strap_eq_a), .strap_eq_b(strap_eq_b),
        .strap_dem_a(strap_dem_a), .strap_dem_b(strap_dem_b),
        .strap_mode(strap_mode), .strap_rxdet(strap_rxdet),
        .strap_sdth(strap_sdth), .strap_lpbk(strap_lpbk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctl_state(ctl_state), .lane_eq(lane_eq), .lane_dem(lane_dem),
        .lane_vod(lane_vod), .lane_term_dis(lane_term_dis),
        .op_mode(op_mode), .rxdet_cfg(rxdet_cfg), .sd_thresh(sd_thresh),
        .loop_sel(loop_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_sel(input logic [1:0] s);
        strap_sel = s;
        settle();
    endtask

    task automatic t_reset();
        chk(ctl_state == 2'b00, "R8 reset state", ctl_state, 0);
        for (int l = 0; l < NL; l++)
            chk(lane_eq[l] == 8'h00 && lane_vod[l] == 3'd2, "R8 reset lanes", lane_eq[l], 0);
        chk(loop_sel == 2'b00, "R10 float normal", loop_sel, 0);
    endtask

    task automatic t_table();
        strap_eq_b = 4'h9;
        for (int i = 0; i < 16; i++) begin
            strap_eq_a = 4'(i);
            strap_dem_a = 4'(15 - i);
            settle();
            for (int l = 0; l < 4; l++) begin
                chk(lane_eq[l] == eq_tab[i], "R3 table side A", lane_eq[l], eq_tab[i]);
                chk(lane_dem[l] == 4'(15 - i), "R2 dem side A", lane_dem[l], 15 - i);
                chk(lane_eq[4 + l] == 8'h1F, "R2 side B independent", lane_eq[4 + l], 8'h1F);
            end
        end
        strap_dem_b = 4'h6;
        settle();
        for (int l = 4; l < NL; l++) begin
            chk(lane_dem[l] == 4'h6, "R2 dem side B", lane_dem[l], 6);
            chk(lane_vod[l] == 3'd2 && !lane_term_dis[l], "R2 pin vod/term", lane_vod[l], 2);
        end
    endtask

    task automatic t_filter();
        strap_eq_a = 4'h0;
        settle();
        strap_eq_a = 4'h5;
        repeat (3) @(negedge clk);
        chk(lane_eq[0] == 8'h00, "R11 not before 4th edge", lane_eq[0], 0);
        @(negedge clk);
        chk(lane_eq[0] == 8'h15, "R11 at 4th edge", lane_eq[0], 8'h15);
        strap_eq_a = 4'hC;
        @(negedge clk);
        strap_eq_a = 4'h5;
        settle();
        chk(lane_eq[0] == 8'h15, "R11 glitch dropped", lane_eq[0], 8'h15);
    endtask

    task automatic t_loop();
        strap_lpbk = 2'b00; settle();
        chk(loop_sel == 2'b01, "R10 A to B", loop_sel, 1);
        strap_lpbk = 2'b11; settle();
        chk(loop_sel == 2'b10, "R10 B to A", loop_sel, 2);
        strap_lpbk = 2'b01; settle();
        chk(loop_sel == 2'b00, "R10 R normal", loop_sel, 0);
        strap_lpbk = 2'b10; settle();
    endtask

    task automatic t_pin_write();
        strap_sel = 2'b01; settle();
        chk(ctl_state == 2'b00, "R1 R level is pin", ctl_state, 0);
        reg_wr(5'd0, 8'h77);
        reg_wr(5'd8, 8'h80);
        chk(lane_term_dis[0] == 1'b0, "R6 pin write no effect", lane_term_dis[0], 0);
        strap_sel = 2'b00; settle();
    endtask

    task automatic t_enter();
        strap_sel = 2'b11;
        repeat (3) @(negedge clk);
        chk(ctl_state == 2'b00 && lane_eq[0] == 8'h15, "R4 before switch", lane_eq[0], 8'h15);
        @(negedge clk);
        chk(ctl_state == 2'b01, "R1 slave", ctl_state, 1);
        chk(lane_eq[0] == 8'h00, "R4 same-cycle switch, R6 write dropped", lane_eq[0], 0);
        for (int l = 0; l < NL; l++) begin
            reg_wr(5'(l), 8'(8'h10 + l));
            reg_wr(5'(8 + l), {1'(l % 2), 3'(l % 8), 4'(15 - l)});
        end
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            chk(lane_eq[l] == 8'(8'h10 + l), "R5 lane eq", lane_eq[l], 8'h10 + l);
            chk(lane_dem[l] == 4'(15 - l), "R5 lane dem", lane_dem[l], 15 - l);
            chk(lane_vod[l] == 3'(l % 8), "R5 lane vod", lane_vod[l], l);
            chk(lane_term_dis[l] == 1'(l % 2), "R4 lane term", lane_term_dis[l], l % 2);
        end
    endtask

    task automatic t_override();
        strap_mode = 2'b01; strap_rxdet = 2'b10; strap_sdth = 2'b11; settle();
        chk(op_mode == 2'b01, "R7 mode follows strap", op_mode, 1);
        reg_wr(5'd16, 8'h03);
        chk(op_mode == 2'b01, "R7 written not enabled", op_mode, 1);
        reg_wr(5'd19, 8'h03);
        chk(op_mode == 2'b11, "R7 override active", op_mode, 3);
        chk(rxdet_cfg == 2'b10, "R7 enabled but unwritten", rxdet_cfg, 2);
        strap_mode = 2'b10; settle();
        chk(op_mode == 2'b11, "R7 override holds vs strap", op_mode, 3);
        reg_wr(5'd19, 8'h00);
        chk(op_mode == 2'b11, "R7 enable sticky", op_mode, 3);
        reg_wr(5'd18, 8'h01);
        chk(sd_thresh == 2'b11, "R7 threshold not enabled", sd_thresh, 3);
    endtask

    task automatic t_pwrdn();
        pwr_dn = 1'b1;
        reg_wr(5'd2, 8'hEE);
        reg_wr(5'd19, 8'h04);
        @(negedge clk);
        chk(lane_eq[2] == 8'h12, "R9 write ignored in power-down", lane_eq[2], 8'h12);
        chk(sd_thresh == 2'b11, "R9 enable ignored in power-down", sd_thresh, 3);
        pwr_dn = 1'b0;
        @(negedge clk);
        chk(lane_eq[7] == 8'h17 && op_mode == 2'b11, "R9 retained after power-down", lane_eq[7], 8'h17);
    endtask

    task automatic t_clear();
        set_sel(2'b00);
        chk(op_mode == 2'b10, "R8 pin mode restores strap", op_mode, 2);
        set_sel(2'b10);
        chk(ctl_state == 2'b10, "R1 load mode", ctl_state, 2);
        for (int l = 0; l < NL; l++)
            chk(lane_eq[l] == 8'h00 && lane_vod[l] == 3'd2, "R8 cleared on pin entry", lane_eq[l], 0);
        chk(op_mode == 2'b10, "R8 override cleared", op_mode, 2);
        reg_wr(5'd5, 8'h5A);
        chk(lane_eq[5] == 8'h5A, "R4 load mode accepts write", lane_eq[5], 8'h5A);
    endtask

    initial begin
        eq_tab = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h15, 8'h0B, 8'h0F,
                   8'h55, 8'h1F, 8'h2F, 8'h3F, 8'hAA, 8'h7F, 8'hBF, 8'hFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_table();
        t_filter();
        t_loop();
        t_pin_write();
        t_enter();
        t_override();
        t_pwrdn();
        t_clear();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule